// File: doc/BRIEF.md
# Programmable Binary Clock Prescaler

This block turns a reference clock into a system-rate timing signal by dividing it by a power of two. The ratio has two parts. A six-stage binary chain gives 1 to 64, with the tap picked by a 3-bit code. A single divide-by-two stage doubles that ratio unless it is bypassed. Both settings are loaded through a one-cycle write strobe and take effect on the next clock edge, with no settling wait.

No derived clock net is created. One free-running counter runs on the reference clock, and the output is a clock-enable pulse, `tick_o`, that downstream logic uses to qualify its own flops. A square wave, `sq_o`, toggles on every tick and is meant for observation only. The block carries no data stream, so it has no valid/ready interface. The write strobe and the settings are plain control pins with no back-pressure.

Top module: `bin_prescaler`

## Requirements
- R1: The divisor is D = 2^min(Y,6) × (2 if X = 0, else 1), and rising edges of `tick_o` are exactly D reference cycles apart.
- R2: Y = 7 gives the same divisor and the same tick pattern as Y = 6.
- R3: X = 1 bypasses the extra stage and X = 0 doubles the divisor, so the largest ratio is 128 (X = 0 with Y = 6 or 7).
- R4: When D > 1, `tick_o` is high for exactly one reference cycle in every D cycles.
- R5: While `rst` is high and after it is released, the settings are X = 1 and Y = 0, so `tick_o` stays high on every cycle.
- R6: A write restarts the count. The first tick after a write is high in the cycle that follows the (D−1)-th clock edge after the write edge. The first tick after a write is therefore consumed by the D-th edge, so no short period ever appears.
- R7: With D = 1, `tick_o` is high on every cycle.
- R8: `sq_o` inverts at every clock edge that samples `tick_o` high, so its period is 2·D.
- R9: `cfg_x` and `cfg_y` are captured only at an edge where `cfg_wr` is high. At all other edges they have no effect on `tick_o` or `sq_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Write strobe for the settings |
| cfg_x | input | 1 | 1 = bypass the extra divide-by-two stage |
| cfg_y | input | 3 | Tap code for the chain (7 acts as 6) |
| tick_o | output | 1 | Clock-enable pulse, one cycle per period |
| sq_o | output | 1 | Square wave toggled by each tick |

## Verification
A corrupted setting register or tap decode shows up as a wrong tick spacing. For large divisors this becomes visible within one period, and for small divisors within a few cycles. A counter that fails to clear on a write moves the first tick after the write, and that error is visible at most D cycles after the write edge. A fault in the toggle flop shows on `sq_o` at the first tick. The bench measures every spacing cycle by cycle over three periods, against a divisor it computes from X and Y.

// File: rtl/bps_pkg.sv
package bps_pkg;
  localparam int unsigned BPS_CHAIN_STAGES = 6;
  localparam int unsigned BPS_TAP_W        = 3;
endpackage

// File: rtl/bps_cfg.sv
module bps_cfg #(
  parameter int unsigned TAP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             x_in,
  input  logic [TAP_W-1:0] y_in,
  output logic             x_q,
  output logic [TAP_W-1:0] y_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= 1'b1;
      y_q <= '0;
    end else if (wr) begin
      x_q <= x_in;
      y_q <= y_in;
    end
  end

  // R5: reset leaves the undivided setting
  p_rst_cfg_r5: assert property (@(posedge clk) rst |=> (x_q && y_q == '0));
  // R9: settings hold without a strobe
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !wr |=> ($stable(x_q) && $stable(y_q)));
endmodule

// File: rtl/bps_tap.sv
module bps_tap #(
  parameter int unsigned CHAIN = 6,
  parameter int unsigned TAP_W = 3,
  parameter int unsigned CNT_W = CHAIN + 1
) (
  input  logic             x_q,
  input  logic [TAP_W-1:0] y_q,
  output logic [CNT_W-1:0] mask
);
  localparam int unsigned SH_W = $clog2(CNT_W + 1);
  logic [SH_W-1:0] tap_sat;
  logic [SH_W-1:0] shift;

  always_comb begin
    if (int'(y_q) > int'(CHAIN)) tap_sat = SH_W'(CHAIN);
    else                         tap_sat = SH_W'(y_q);
    shift = tap_sat + (x_q ? SH_W'(0) : SH_W'(1));
  end

  for (genvar b = 0; b < CNT_W; b++) begin : g_mask
    assign mask[b] = (int'(shift) > b);
  end
endmodule

// File: rtl/bps_counter.sv
module bps_counter #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [CNT_W-1:0] mask,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  assign tick = &(cnt | ~mask);

  // R6: a write restarts the count
  p_clear_r6: assert property (@(posedge clk) disable iff (rst) clear |=> (cnt == '0));
  // R4: a tick lasts one cycle when the divisor exceeds one
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && mask != '0 && !clear) |=> !tick);
endmodule

// File: rtl/bps_square.sv
module bps_square (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic sq
);
  always_ff @(posedge clk) begin
    if (rst)       sq <= 1'b0;
    else if (tick) sq <= ~sq;
  end

  // R8: toggle on every tick
  p_sq_toggle_r8: assert property (@(posedge clk) disable iff (rst)
    tick |=> (sq != $past(sq)));
endmodule

// File: rtl/bin_prescaler.sv
module bin_prescaler
  import bps_pkg::*;
#(
  parameter int unsigned CHAIN = BPS_CHAIN_STAGES,
  parameter int unsigned TAP_W = BPS_TAP_W
) (
  input  logic             clk_ref,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic             cfg_x,
  input  logic [TAP_W-1:0] cfg_y,
  output logic             tick_o,
  output logic             sq_o
);
  localparam int unsigned CNT_W = CHAIN + 1;

  logic             x_q;
  logic [TAP_W-1:0] y_q;
  logic [CNT_W-1:0] mask;

  bps_cfg #(.TAP_W(TAP_W)) u_cfg (
    .clk(clk_ref), .rst(rst), .wr(cfg_wr), .x_in(cfg_x), .y_in(cfg_y),
    .x_q(x_q), .y_q(y_q)
  );

  bps_tap #(.CHAIN(CHAIN), .TAP_W(TAP_W), .CNT_W(CNT_W)) u_tap (
    .x_q(x_q), .y_q(y_q), .mask(mask)
  );

  bps_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk_ref), .rst(rst), .clear(cfg_wr), .mask(mask), .tick(tick_o)
  );

  bps_square u_sq (
    .clk(clk_ref), .rst(rst), .tick(tick_o), .sq(sq_o)
  );

  // R7: the undivided setting ticks on every cycle
  p_unit_tick_r7: assert property (@(posedge clk_ref) disable iff (rst)
    (x_q && y_q == '0) |-> tick_o);
endmodule

// File: tb/bin_prescaler_bench.sv
module bin_prescaler_bench;
  logic       clk_ref = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic       cfg_x = 1'b0;
  logic [2:0] cfg_y = 3'd0;
  logic       tick_o;
  logic       sq_o;
  int checks = 0;
  int fails  = 0;

  always #2 clk_ref = ~clk_ref;

  bin_prescaler u_bin_prescaler (
    .clk_ref(clk_ref), .rst(rst), .cfg_wr(cfg_wr), .cfg_x(cfg_x),
    .cfg_y(cfg_y), .tick_o(tick_o), .sq_o(sq_o)
  );

  function automatic int exp_div(bit x, int y);
    int t;
    t = (y > 6) ? 6 : y;
    return (1 << t) * (x ? 1 : 2);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // write at one edge, then watch 3*D cycles while scrambling data with strobe low (R9)
  task automatic program_and_measure(bit x, int y, string req);
    int d;
    int bad_tick;
    int bad_sq;
    int first_i;
    int act_sp;
    bit esq;
    d = exp_div(x, y);
    @(negedge clk_ref);
    cfg_wr = 1'b1; cfg_x = x; cfg_y = 3'(y);
    @(posedge clk_ref);
    @(negedge clk_ref);
    cfg_wr = 1'b0;
    bad_tick = -1; bad_sq = -1; first_i = -1; act_sp = -1;
    esq = sq_o;
    for (int i = 0; i < 3 * d; i++) begin
      bit et;
      et = ((i + 1) % d) == 0;
      if (tick_o !== et && bad_tick < 0) bad_tick = i;
      if (sq_o !== esq && bad_sq < 0) bad_sq = i;
      if (tick_o === 1'b1) begin
        if (first_i < 0) first_i = i;
        else if (act_sp < 0) act_sp = i - first_i;
      end
      if (et) esq = ~esq;
      cfg_x = 1'($urandom); cfg_y = 3'($urandom);
      @(negedge clk_ref);
    end
    check(first_i == d - 1, {"R6 first tick ", req}, first_i, d - 1);
    if (d > 1) check(act_sp == d, {"R1 spacing ", req}, act_sp, d);
    check(bad_tick < 0, {"R4/R9 tick pattern ", req}, bad_tick, -1);
    check(bad_sq < 0, {"R8 square ", req}, bad_sq, -1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_ref);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    bit s0;
    seed = $urandom(32'd4711);
    // R5: reset state
    repeat (3) @(negedge clk_ref);
    check(tick_o === 1'b1, "R5 tick in reset", int'(tick_o), 1);
    check(sq_o === 1'b0, "R5 square in reset", int'(sq_o), 0);
    rst = 1'b0;
    @(negedge clk_ref);
    s0 = sq_o;
    for (int i = 0; i < 4; i++) begin
      check(tick_o === 1'b1, "R5 R7 tick after reset", int'(tick_o), 1);
      @(negedge clk_ref);
    end
    check(sq_o === s0, "R8 square after four ticks", int'(sq_o), int'(s0));
    // R1 R3: full sweep including Y=7 (R2)
    for (int x = 0; x < 2; x++)
      for (int y = 0; y < 8; y++)
        program_and_measure(bit'(x), y, (y == 7) ? "R2 y7" : "R3 sweep");
    // R3: largest ratio directed
    program_and_measure(1'b0, 6, "R3 max128");
    program_and_measure(1'b1, 0, "R7 unity");
    // random mix
    for (int k = 0; k < 12; k++)
      program_and_measure(1'($urandom), int'(3'($urandom)), "R1 random");
    // R5: reset again restores undivided output
    @(negedge clk_ref); rst = 1'b1;
    @(negedge clk_ref); rst = 1'b0;
    @(negedge clk_ref);
    check(tick_o === 1'b1, "R5 reset restores", int'(tick_o), 1);
    @(negedge clk_ref);
    check(tick_o === 1'b1, "R5 reset restores", int'(tick_o), 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule